// File: doc/BRIEF.md
# Instruction Length Decoder

This block looks at a window of up to 16 code bytes and returns the length in bytes of the one instruction that starts at byte 0 of the window. The decode uses 32-bit protected-mode rules. It works through the fields of the instruction in order: legacy prefix bytes, a one-byte opcode or an opcode escaped by 0x0F, an optional ModR/M byte, an optional SIB byte, a displacement, and an immediate. It does not decode anything beyond the length. A fetch or predecode stage can use the result to find where the next instruction begins.

Each opcode belongs to a length class. The class says whether a ModR/M byte follows and how large the immediate is. The classes cover the accumulator short forms, the forms that hold a register number in the opcode itself, and the group forms whose immediate depends on the ModR/M reg field. Any opcode outside the supported subset is reported as unsupported. An address-size override is reported the same way, because 16-bit addressing is not handled. The result is registered and appears one clock after the input strobe.

Top module: `ild_len_decode`

## Requirements
- R1: The bytes 66, 67, F0, F2, F3, 26, 2E, 36, 3E, 64 and 65 are prefixes when they lead the window. Each one adds 1 byte, and at most 14 are counted. The byte after the counted prefixes is the opcode. If that byte is itself a prefix value, the opcode is unsupported.
- R2: When a 66 prefix is present, a full-size immediate (normally 4 bytes) takes 2 bytes. Byte-size immediates keep 1 byte.
- R3: Byte 0F is an escape, and the byte after it selects the operation. The supported second bytes are:
  - 80–8F: 4-byte (full-size) immediate, no ModR/M.
  - 40–4F, 90–9F, 1F, AF, B6, B7, BC, BD, BE, BF: ModR/M, no immediate.
  - BA: ModR/M plus imm8.
  - A2: nothing further.
- R4: Opcodes that carry a register number in their low 3 bits have no ModR/M byte:
  - 40–5F and 90–97: 1 byte.
  - B0–B7: 2 bytes.
  - B8–BF: opcode plus a full-size immediate.
- R5: The ALU opcodes 00–3F behave by their low 3 bits:
  - Low bits 0–3: take ModR/M.
  - Low bits 4: imm8 with no ModR/M.
  - Low bits 5: full-size immediate with no ModR/M.
  - 80 and 83: ModR/M plus imm8.
  - 81: ModR/M plus a full-size immediate.
- R6: The ModR/M byte adds 1 byte, plus a displacement chosen by its mode bits [7:6]:
  - Mode 11: no displacement.
  - Mode 01: 1 byte.
  - Mode 10: 4 bytes.
  - Mode 00 with r/m bits [2:0] = 101: 4 bytes.
- R7: When the mode is not 11 and r/m = 100, a SIB byte follows (+1). With mode 00 and SIB base bits [2:0] = 101, a 4-byte displacement is added.
- R8: F6 and F7 carry an immediate only when the ModR/M reg field [5:3] is 000. F6 then takes imm8 and F7 takes a full-size immediate. Other reg values give no immediate.
- R9: D0–D3 (shift or rotate by an implied count of 1, or by CL) take ModR/M and no immediate. C0 and C1 take ModR/M plus imm8.
- R10: An unsupported opcode, or any 67 prefix, gives out_unsup = 1, out_legal = 0 and out_len = 0.
- R11: A supported instruction longer than 15 bytes gives out_legal = 0, out_unsup = 0 and out_len = 15. Exactly 15 bytes is legal.
- R12: out_done pulses in the cycle after each in_valid cycle. out_len, out_legal and out_unsup change only on a strobe.
- R13: During reset, out_done, out_len, out_legal and out_unsup are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Strobe: the window is to be decoded |
| in_bytes | input | 128 | Code window; byte i sits at bits [8i+7:8i] |
| out_done | output | 1 | Result strobe, one cycle after in_valid |
| out_len | output | 4 | Instruction length in bytes |
| out_legal | output | 1 | Supported and no longer than 15 bytes |
| out_unsup | output | 1 | Opcode outside the subset, or address-size override present |

## Verification
The directed windows separate the ModR/M cases from one another:
- register mode against memory mode;
- each displacement size;
- the r/m=100 SIB case, including the mode-00 base-101 case that adds a disp32;
- the mode-11 r/m=100 case, which must not pull in a SIB byte.

Paired windows with and without the 66 prefix show whether the immediate shrinks for full-size forms only. The F6/F7 pairs check that the immediate depends on the reg field. Runs of prefixes hit the 15-byte limit from both sides and reach the prefix cap. Random windows are built around supported opcodes with random trailing bytes, mixed with fully random windows, so many class and addressing combinations meet a bench model.

// File: rtl/ild_pkg.sv
package ild_pkg;

  typedef enum logic [1:0] {
    IMM_NONE = 2'd0,
    IMM_BYTE = 2'd1,
    IMM_FULL = 2'd2
  } imm_kind_e;

  typedef struct packed {
    logic      known;
    logic      has_modrm;
    imm_kind_e imm;
  } op_class_t;

  function automatic logic is_prefix(input logic [7:0] b);
    case (b)
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3,
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ild_pfx_scan.sv
module ild_pfx_scan
  import ild_pkg::*;
#(
  parameter int MAX_PFX = 14,
  parameter int CNT_W   = $clog2(MAX_PFX + 1)
) (
  input  logic [MAX_PFX*8-1:0] lead,
  output logic [CNT_W-1:0]     count,
  output logic                 opsize,
  output logic                 addrsize
);

  logic run;

  always_comb begin
    run      = 1'b1;
    count    = '0;
    opsize   = 1'b0;
    addrsize = 1'b0;
    for (int i = 0; i < MAX_PFX; i++) begin
      if (run && is_prefix(lead[8*i +: 8])) begin
        count = count + CNT_W'(1);
        if (lead[8*i +: 8] == 8'h66) opsize   = 1'b1;
        if (lead[8*i +: 8] == 8'h67) addrsize = 1'b1;
      end else begin
        run = 1'b0;
      end
    end
  end

endmodule

// File: rtl/ild_op_class.sv
module ild_op_class
  import ild_pkg::*;
(
  input  logic       esc,
  input  logic [7:0] opc,
  input  logic [2:0] reg_f,
  output op_class_t  cls
);

  op_class_t one_b, two_b;

  // single-byte opcode map
  always_comb begin
    one_b = '{known: 1'b1, has_modrm: 1'b0, imm: IMM_NONE};
    if (opc[7:6] == 2'b00) begin
      case (opc[2:0])
        3'd0, 3'd1, 3'd2, 3'd3: one_b.has_modrm = 1'b1;
        3'd4:                   one_b.imm = IMM_BYTE;
        3'd5:                   one_b.imm = IMM_FULL;
        default: begin
          case (opc)
            8'h06, 8'h07, 8'h0E, 8'h16, 8'h17, 8'h1E, 8'h1F: ;
            default: one_b.known = 1'b0;
          endcase
        end
      endcase
    end else begin
      case (opc) inside
        [8'h40:8'h5F], [8'h90:8'h99],
        8'hC3, 8'hC9, 8'hCC, 8'hF4, 8'hF5, [8'hF8:8'hFD]: ;
        8'h68, [8'hB8:8'hBF], 8'hE8, 8'hE9:
          one_b.imm = IMM_FULL;
        8'h6A, [8'h70:8'h7F], 8'hA8, [8'hB0:8'hB7], 8'hCD, 8'hEB:
          one_b.imm = IMM_BYTE;
        8'hA9:
          one_b.imm = IMM_FULL;
        [8'h84:8'h8B], 8'h8D, 8'h8F, [8'hD0:8'hD3], 8'hFE, 8'hFF:
          one_b.has_modrm = 1'b1;
        8'h80, 8'h83, 8'h6B, 8'hC0, 8'hC1, 8'hC6: begin
          one_b.has_modrm = 1'b1;
          one_b.imm       = IMM_BYTE;
        end
        8'h81, 8'h69, 8'hC7: begin
          one_b.has_modrm = 1'b1;
          one_b.imm       = IMM_FULL;
        end
        8'hF6: begin
          one_b.has_modrm = 1'b1;
          one_b.imm       = (reg_f == 3'b000) ? IMM_BYTE : IMM_NONE;
        end
        8'hF7: begin
          one_b.has_modrm = 1'b1;
          one_b.imm       = (reg_f == 3'b000) ? IMM_FULL : IMM_NONE;
        end
        default: one_b.known = 1'b0;
      endcase
    end
  end

  // escaped opcode map
  always_comb begin
    two_b = '{known: 1'b1, has_modrm: 1'b0, imm: IMM_NONE};
    case (opc) inside
      [8'h80:8'h8F]: two_b.imm = IMM_FULL;
      [8'h40:8'h4F], [8'h90:8'h9F], 8'h1F, 8'hAF,
      8'hB6, 8'hB7, 8'hBC, 8'hBD, 8'hBE, 8'hBF:
        two_b.has_modrm = 1'b1;
      8'hBA: begin
        two_b.has_modrm = 1'b1;
        two_b.imm       = IMM_BYTE;
      end
      8'hA2: ;
      default: two_b.known = 1'b0;
    endcase
  end

  assign cls = esc ? two_b : one_b;

endmodule

// File: rtl/ild_addr_len.sv
module ild_addr_len (
  input  logic [1:0] mode,
  input  logic [2:0] rm,
  input  logic [2:0] sib_base,
  output logic [2:0] nbytes
);

  logic       has_sib;
  logic [2:0] disp;

  always_comb begin
    has_sib = (mode != 2'b11) && (rm == 3'b100);
    case (mode)
      2'b01:   disp = 3'd1;
      2'b10:   disp = 3'd4;
      2'b00:   disp = ((rm == 3'b101) || (has_sib && sib_base == 3'b101)) ? 3'd4 : 3'd0;
      default: disp = 3'd0;
    endcase
    nbytes = 3'd1 + {2'b00, has_sib} + disp;
  end

endmodule

// File: rtl/ild_len_decode.sv
module ild_len_decode
  import ild_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int MAX_PFX   = 14,
  parameter int LEN_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [WIN_BYTES*8-1:0] in_bytes,
  output logic                   out_done,
  output logic [LEN_W-1:0]       out_len,
  output logic                   out_legal,
  output logic                   out_unsup
);

  localparam int WIN_W   = WIN_BYTES * 8;
  localparam int CNT_W   = $clog2(MAX_PFX + 1);
  localparam int IDX_W   = $clog2(WIN_BYTES + 4);
  localparam int MAX_LEN = (1 << LEN_W) - 1;
  localparam int SUM_W   = $clog2(MAX_PFX + 2 + 6 + 4 + 1);

  // bytes past the window read as zero
  function automatic logic [7:0] pick(input logic [WIN_W-1:0] w, input logic [IDX_W-1:0] idx);
    logic [7:0] r;
    r = 8'h00;
    for (int k = 0; k < WIN_BYTES; k++)
      if (idx == IDX_W'(k)) r = w[8*k +: 8];
    return r;
  endfunction

  function automatic logic [2:0] pick_lo3(input logic [WIN_W-1:0] w, input logic [IDX_W-1:0] idx);
    logic [2:0] r;
    r = 3'b000;
    for (int k = 0; k < WIN_BYTES; k++)
      if (idx == IDX_W'(k)) r = w[8*k +: 3];
    return r;
  endfunction

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // field walk
  logic [CNT_W-1:0] pfx_cnt;
  logic             opsize, addrsize;

  ild_pfx_scan #(.MAX_PFX(MAX_PFX), .CNT_W(CNT_W)) u_scan (
    .lead     (in_bytes[MAX_PFX*8-1:0]),
    .count    (pfx_cnt),
    .opsize   (opsize),
    .addrsize (addrsize)
  );

  logic [IDX_W-1:0] pos;
  logic [7:0]       first_b, opc, modrm;
  logic [2:0]       sib_base;
  logic             esc;

  always_comb begin
    pos      = IDX_W'(pfx_cnt);
    first_b  = pick(in_bytes, pos);
    esc      = (first_b == 8'h0F);
    opc      = esc ? pick(in_bytes, pos + IDX_W'(1)) : first_b;
    modrm    = pick(in_bytes, pos + IDX_W'(1) + IDX_W'(esc));
    sib_base = pick_lo3(in_bytes, pos + IDX_W'(2) + IDX_W'(esc));
  end

  op_class_t  cls;
  logic [2:0] addr_n;

  ild_op_class u_class (
    .esc   (esc),
    .opc   (opc),
    .reg_f (modrm[5:3]),
    .cls   (cls)
  );

  ild_addr_len u_addr (
    .mode     (modrm[7:6]),
    .rm       (modrm[2:0]),
    .sib_base (sib_base),
    .nbytes   (addr_n)
  );

  // length sum and flags (next state)
  logic [2:0]       imm_n;
  logic [SUM_W-1:0] total;
  logic             unsup_d, long_d, legal_d;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    case (cls.imm)
      IMM_BYTE: imm_n = 3'd1;
      IMM_FULL: imm_n = opsize ? 3'd2 : 3'd4;
      default:  imm_n = 3'd0;
    endcase
    total = SUM_W'(pfx_cnt) + SUM_W'(1) + SUM_W'(esc)
          + (cls.has_modrm ? SUM_W'(addr_n) : SUM_W'(0))
          + SUM_W'(imm_n);
    unsup_d = !cls.known || addrsize;
    long_d  = total > SUM_W'(MAX_LEN);
    legal_d = !unsup_d && !long_d;
    if (unsup_d)     len_d = '0;
    else if (long_d) len_d = LEN_W'(MAX_LEN);
    else             len_d = total[LEN_W-1:0];
  end

  // registers
  logic             done_q, legal_q, unsup_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      len_q   <= '0;
      legal_q <= 1'b0;
      unsup_q <= 1'b0;
    end else if (in_valid) begin
      len_q   <= len_d;
      legal_q <= legal_d;
      unsup_q <= unsup_d;
    end
  end

  assign out_done  = done_q;
  assign out_len   = len_q;
  assign out_legal = legal_q;
  assign out_unsup = unsup_q;

endmodule

// File: rtl/ild_len_decode_chk.sv
module ild_len_decode_chk #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             arst_n,
  input logic             srst_n,
  input logic             in_valid,
  input logic             out_done,
  input logic [LEN_W-1:0] out_len,
  input logic             out_legal,
  input logic             out_unsup
);

  p_done_after_strobe_r12: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
    in_valid |=> out_done);

  p_no_spurious_done_r12: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
    !in_valid |=> !out_done);

  p_hold_without_strobe_r12: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
    !in_valid |=> ($stable(out_len) && $stable(out_legal) && $stable(out_unsup)));

  p_unsup_clears_r10: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
    out_unsup |-> (!out_legal && out_len == '0));

  p_legal_nonzero_r11: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
    out_legal |-> (out_len != '0));

  p_too_long_saturates_r11: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
    (out_done && !out_legal && !out_unsup) |-> (out_len == '1));

endmodule

bind ild_len_decode ild_len_decode_chk #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .arst_n    (rst_n),
  .srst_n    (rst_sync_n),
  .in_valid  (in_valid),
  .out_done  (out_done),
  .out_len   (out_len),
  .out_legal (out_legal),
  .out_unsup (out_unsup)
);

// File: tb/sim_ild_len_decode.sv
module sim_ild_len_decode;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_bytes = '0;
  logic         out_done, out_legal, out_unsup;
  logic [3:0]   out_len;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ild_len_decode u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
    .out_done(out_done), .out_len(out_len), .out_legal(out_legal), .out_unsup(out_unsup)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- bench model ----------------
  function automatic logic [7:0] bt(input logic [127:0] w, input int i);
    return (i < 16) ? w[8*i +: 8] : 8'h00;
  endfunction

  function automatic bit pfx_b(input logic [7:0] b);
    return b inside {8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65};
  endfunction

  function automatic void model(input logic [127:0] w, output int len, output bit legal, output bit unsup);
    int p = 0, pos, full, imm, tot, amod;
    bit osz = 0, asz = 0, esc, ok, mr;
    logic [7:0] op, m, s;
    while (p < 14 && pfx_b(bt(w, p))) begin
      if (bt(w, p) == 8'h66) osz = 1;
      if (bt(w, p) == 8'h67) asz = 1;
      p++;
    end
    pos  = p;
    esc  = (bt(w, pos) == 8'h0F);
    op   = esc ? bt(w, pos + 1) : bt(w, pos);
    m    = bt(w, pos + 1 + int'(esc));
    s    = bt(w, pos + 2 + int'(esc));
    full = osz ? 2 : 4;
    ok = 1; mr = 0; imm = 0;
    if (esc) begin
      if (op inside {[8'h80:8'h8F]}) imm = full;
      else if (op inside {[8'h40:8'h4F], [8'h90:8'h9F], 8'h1F, 8'hAF, 8'hB6, 8'hB7, 8'hBC, 8'hBD, 8'hBE, 8'hBF}) mr = 1;
      else if (op == 8'hBA) begin mr = 1; imm = 1; end
      else if (op != 8'hA2) ok = 0;
    end else if (op < 8'h40) begin
      if (op[2:0] <= 3) mr = 1;
      else if (op[2:0] == 4) imm = 1;
      else if (op[2:0] == 5) imm = full;
      else if (!(op inside {8'h06, 8'h07, 8'h0E, 8'h16, 8'h17, 8'h1E, 8'h1F})) ok = 0;
    end else if (op inside {[8'h40:8'h5F], [8'h90:8'h99], 8'hC3, 8'hC9, 8'hCC, 8'hF4, 8'hF5, [8'hF8:8'hFD]}) ;
    else if (op inside {8'h68, [8'hB8:8'hBF], 8'hE8, 8'hE9, 8'hA9}) imm = full;
    else if (op inside {8'h6A, [8'h70:8'h7F], 8'hA8, [8'hB0:8'hB7], 8'hCD, 8'hEB}) imm = 1;
    else if (op inside {[8'h84:8'h8B], 8'h8D, 8'h8F, [8'hD0:8'hD3], 8'hFE, 8'hFF}) mr = 1;
    else if (op inside {8'h80, 8'h83, 8'h6B, 8'hC0, 8'hC1, 8'hC6}) begin mr = 1; imm = 1; end
    else if (op inside {8'h81, 8'h69, 8'hC7}) begin mr = 1; imm = full; end
    else if (op == 8'hF6) begin mr = 1; imm = (m[5:3] == 0) ? 1 : 0; end
    else if (op == 8'hF7) begin mr = 1; imm = (m[5:3] == 0) ? full : 0; end
    else ok = 0;
    amod = 0;
    if (mr) begin
      amod = 1;
      if (m[7:6] != 2'b11 && m[2:0] == 3'b100) amod += 1;
      if (m[7:6] == 2'b01) amod += 1;
      else if (m[7:6] == 2'b10) amod += 4;
      else if (m[7:6] == 2'b00 && (m[2:0] == 3'b101 || (m[2:0] == 3'b100 && s[2:0] == 3'b101))) amod += 4;
    end
    tot = p + 1 + int'(esc) + amod + imm;
    unsup = !ok || asz;
    legal = !unsup && tot <= 15;
    len   = unsup ? 0 : (tot > 15 ? 15 : tot);
  endfunction

  // ---------------- drivers ----------------
  task automatic apply(input string req, input logic [127:0] w, input int elen, input bit elegal, input bit eunsup);
    @(negedge clk);
    in_valid = 1'b1;
    in_bytes = w;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12", {req, " done"}, int'(out_done), 1);
    chk(req, "len", int'(out_len), elen);
    chk(req, "legal", int'(out_legal), int'(elegal));
    chk(req, "unsup", int'(out_unsup), int'(eunsup));
  endtask

  // bytes given first-to-last, right aligned in v, n of them; rest of window zero
  function automatic logic [127:0] pack(input int n, input logic [127:0] v);
    logic [127:0] w = '0;
    for (int i = 0; i < n; i++) w[8*i +: 8] = v[8*(n-1-i) +: 8];
    return w;
  endfunction

  task automatic dir(input string req, input int n, input logic [127:0] v, input int elen, input bit elegal, input bit eunsup);
    apply(req, pack(n, v), elen, elegal, eunsup);
  endtask

  logic [7:0] one_list [24] = '{8'h01, 8'h04, 8'h05, 8'h0E, 8'h4A, 8'h5B, 8'h68, 8'h69, 8'h6B, 8'h75, 8'h81,
                                8'h83, 8'h8D, 8'h93, 8'hA9, 8'hB3, 8'hBC, 8'hC1, 8'hC7, 8'hD1, 8'hE8, 8'hF6, 8'hF7, 8'hFF};
  logic [7:0] two_list [8]  = '{8'h84, 8'h1F, 8'h44, 8'h95, 8'hAF, 8'hB6, 8'hBA, 8'hA2};
  logic [7:0] pfx_list [6]  = '{8'h66, 8'h66, 8'hF3, 8'h2E, 8'h64, 8'h67};

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] w;
    int el;
    bit eg, eu;
    void'($urandom(32'd20240611));

    // R13: reset state
    repeat (3) @(negedge clk);
    chk("R13", "done", int'(out_done), 0);
    chk("R13", "len", int'(out_len), 0);
    chk("R13", "legal", int'(out_legal), 0);
    chk("R13", "unsup", int'(out_unsup), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: ModR/M modes
    dir("R6", 2, {8'h01, 8'hC8}, 2, 1, 0);
    dir("R6", 2, {8'h03, 8'h08}, 2, 1, 0);
    dir("R6", 3, {8'h8B, 8'h45, 8'h08}, 3, 1, 0);
    dir("R6", 6, {8'h8B, 8'h80, 32'h11223344}, 6, 1, 0);
    dir("R6", 6, {8'h8B, 8'h05, 32'h11223344}, 6, 1, 0);
    // R7: SIB
    dir("R7", 3, {8'h8B, 8'h04, 8'h24}, 3, 1, 0);
    dir("R7", 7, {8'h8B, 8'h04, 8'h25, 32'h0}, 7, 1, 0);
    dir("R7", 4, {8'h8B, 8'h44, 8'h24, 8'h08}, 4, 1, 0);
    dir("R7", 7, {8'h8B, 8'h84, 8'h24, 32'h0}, 7, 1, 0);
    dir("R7", 3, {8'h8B, 8'hC4, 8'h25}, 2, 1, 0);
    // R5 / R2: accumulator and group forms
    dir("R5", 2, {8'h24, 8'h7F}, 2, 1, 0);
    dir("R5", 5, {8'h25, 32'h0}, 5, 1, 0);
    dir("R2", 4, {8'h66, 8'h25, 16'h0}, 4, 1, 0);
    dir("R5", 3, {8'h83, 8'hE0, 8'hFF}, 3, 1, 0);
    dir("R5", 6, {8'h81, 8'hE0, 32'h0}, 6, 1, 0);
    dir("R2", 5, {8'h66, 8'h81, 8'hE0, 16'h0}, 5, 1, 0);
    dir("R2", 4, {8'h66, 8'h83, 8'hE0, 8'hFF}, 4, 1, 0);
    // R4: register in opcode
    dir("R4", 2, {8'hB0, 8'h12}, 2, 1, 0);
    dir("R4", 5, {8'hB8, 32'h0}, 5, 1, 0);
    dir("R4", 4, {8'h66, 8'hB8, 16'h0}, 4, 1, 0);
    dir("R4", 1, {8'h50}, 1, 1, 0);
    dir("R4", 1, {8'h90}, 1, 1, 0);
    dir("R4", 1, {8'h40}, 1, 1, 0);
    dir("R4", 1, {8'h97}, 1, 1, 0);
    // R3: escaped opcodes
    dir("R3", 3, {8'h0F, 8'hB6, 8'hC0}, 3, 1, 0);
    dir("R3", 6, {8'h0F, 8'h84, 32'h0}, 6, 1, 0);
    dir("R3", 5, {8'h66, 8'h0F, 8'h84, 16'h0}, 5, 1, 0);
    dir("R3", 4, {8'h0F, 8'hBA, 8'hE0, 8'h05}, 4, 1, 0);
    dir("R3", 2, {8'h0F, 8'hA2}, 2, 1, 0);
    // R8: F6/F7 reg-field immediate
    dir("R8", 3, {8'hF6, 8'hC0, 8'h01}, 3, 1, 0);
    dir("R8", 2, {8'hF6, 8'hD0}, 2, 1, 0);
    dir("R8", 6, {8'hF7, 8'hC0, 32'h0}, 6, 1, 0);
    dir("R8", 2, {8'hF7, 8'hD8}, 2, 1, 0);
    dir("R8", 5, {8'h66, 8'hF7, 8'hC0, 16'h0}, 5, 1, 0);
    // R9: shifts
    dir("R9", 2, {8'hD1, 8'hE0}, 2, 1, 0);
    dir("R9", 2, {8'hD0, 8'hC0}, 2, 1, 0);
    dir("R9", 3, {8'hC1, 8'hE0, 8'h05}, 3, 1, 0);
    dir("R9", 3, {8'hD1, 8'h04, 8'h24}, 3, 1, 0);
    // R1: prefixes
    dir("R1", 3, {8'hF0, 8'h01, 8'h08}, 3, 1, 0);
    dir("R1", 6, {8'h2E, 8'h3E, 8'h64, 8'h65, 8'h8B, 8'h00}, 6, 1, 0);
    w = '0; for (int i = 0; i < 14; i++) w[8*i +: 8] = 8'hF3; w[8*14 +: 8] = 8'h90;
    apply("R1", w, 15, 1, 0);
    // R11: length limit
    w = '0; for (int i = 0; i < 14; i++) w[8*i +: 8] = 8'h26; w[8*14 +: 8] = 8'h0F; w[8*15 +: 8] = 8'h84;
    apply("R11", w, 15, 0, 0);
    dir("R11", 15, {8'h26, 8'h2E, 8'h36, 8'hF3, 8'h81, 8'h84, 8'h24, 32'h0, 32'h0}, 15, 1, 0);
    dir("R11", 16, {8'h26, 8'h2E, 8'h36, 8'hF3, 8'h64, 8'h81, 8'h84, 8'h24, 32'h0, 32'h0}, 15, 0, 0);
    // R10: unsupported
    w = '0; for (int i = 0; i < 16; i++) w[8*i +: 8] = 8'h3E;
    apply("R10", w, 0, 0, 1);
    dir("R10", 2, {8'h0F, 8'h0B}, 0, 0, 1);
    dir("R10", 3, {8'h82, 8'hC0, 8'h01}, 0, 0, 1);
    dir("R10", 1, {8'h27}, 0, 0, 1);
    dir("R10", 2, {8'hD8, 8'hC0}, 0, 0, 1);
    dir("R10", 3, {8'h67, 8'h8B, 8'h00}, 0, 0, 1);
    dir("R10", 3, {8'h0F, 8'h38, 8'h00}, 0, 0, 1);

    // R12: outputs hold without a strobe
    dir("R12", 5, {8'hB8, 32'h0}, 5, 1, 0);
    @(negedge clk);
    in_bytes = pack(1, {8'h82});
    @(negedge clk);
    chk("R12", "idle done", int'(out_done), 0);
    chk("R12", "held len", int'(out_len), 5);
    chk("R12", "held legal", int'(out_legal), 1);
    chk("R12", "held unsup", int'(out_unsup), 0);

    // random windows against the bench model
    for (int n = 0; n < 400; n++) begin
      int np, pos, kind;
      for (int i = 0; i < 4; i++) w[32*i +: 32] = $urandom;
      kind = $urandom_range(0, 9);
      if (kind != 0) begin
        np = $urandom_range(0, 3);
        for (int i = 0; i < np; i++) w[8*i +: 8] = pfx_list[$urandom_range(0, 5)];
        pos = np;
        if (kind < 8) begin
          w[8*pos +: 8] = one_list[$urandom_range(0, 23)];
        end else begin
          w[8*pos +: 8] = 8'h0F;
          w[8*(pos+1) +: 8] = two_list[$urandom_range(0, 7)];
        end
      end
      model(w, el, eg, eu);
      apply(eu ? "R10" : (eg ? "R6" : "R11"), w, el, eg, eu);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule